// File: doc/BRIEF.md
# Registered-Mode Output Macrocell

This block is one output cell of a small programmable logic array running in its registered mode. The AND array outside the block has already formed a vector of product terms. The cell ORs those terms into a sum and gives the sum a selectable polarity. It then presents the result at its pin, either through a D flip-flop or directly. The cell also produces the pin's tri-state enable and returns a feedback bit to the array.

Two static configuration inputs shape the cell. `cfg_comb` picks registered output (0) or combinatorial I/O (1). `cfg_pol` picks active-high (1) or active-low (0) output.

In registered form, all `NTERM` terms feed the sum. The pin follows the flip-flop, and the enable comes from a shared, active-low enable input.

In combinatorial form, only the lower `NTERM-1` terms feed the sum. The top term becomes this cell's own output enable. The feedback bit is taken from the pin, so the cell can also serve as a plain input (enable held low) or as a plain output (enable held high).

A synchronous reset clears the flip-flop so that operation starts from a known state.

Top module: `pal_macrocell`

## Requirements
- R1: With `cfg_comb`=0, the flip-flop captures the sum of all `NTERM` product terms on a rising `clk` edge. `pin_out` shows the polarity-adjusted value from that edge onward. The top term `pt[NTERM-1]` is part of this sum.
- R2: Polarity: with `cfg_pol`=1 the pin level equals the OR sum (active high). With `cfg_pol`=0 it equals the inverted sum (active low). This holds in both configurations.
- R3: With `cfg_comb`=1, `pin_out` follows the OR of `pt[NTERM-2:0]` in the same cycle without a clock. `pt[NTERM-1]` has no effect on `pin_out`.
- R4: With `cfg_comb`=1, `pin_oe` equals `pt[NTERM-1]`, and `oe_n` has no effect on it.
- R5: With `cfg_comb`=0, `pin_oe` is 1 exactly when `oe_n` is 0 (shared active-low enable).
- R6: With `cfg_comb`=0, `fb` equals the flip-flop's Q, which is always the complement of `pin_out`.
- R7: With `cfg_comb`=1, `fb` equals `pin_in` while `pin_oe`=0 (dedicated input use). It equals `pin_out` while `pin_oe`=1 (dedicated output use).
- R8: A high `rst` at a rising edge clears Q to 0. In registered configuration this makes `pin_out`=1 and `fb`=0 until the next non-reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared register clock |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| pt | input | NTERM | Product terms from the AND array |
| cfg_comb | input | 1 | 0 = registered output, 1 = combinatorial I/O |
| cfg_pol | input | 1 | 1 = active-high output, 0 = active-low output |
| oe_n | input | 1 | Shared output enable, active low (registered form only) |
| pin_in | input | 1 | Level seen on the pin when the cell does not drive it |
| pin_out | output | 1 | Data value driven toward the pin |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb | output | 1 | Feedback bit to the AND array |

## Verification
The bench sets only the top product term while the other terms are clear, in both configurations. A cell that summed the wrong number of terms would show a wrong pin value in one configuration or the other. It drives `oe_n` and the top term against each other, which exposes an enable taken from the wrong source. It toggles `pin_in` while the cell's output is disabled, so feedback taken from the flip-flop instead of the pin in combinatorial form would not follow `pin_in`. It also flips polarity and configuration between clock edges. A design that inverted the wrong stage would then be caught, as would one that gated the clocked path on the configuration, or one whose reset left the pin low.

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTERM-1:0] pt,
  input  logic             cfg_comb,
  input  logic             cfg_pol,
  input  logic             oe_n,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb
);
  localparam int NSUM_C = NTERM - 1;

  logic sum_reg, sum_comb, lvl_reg, lvl_comb, q;

  assign sum_reg  = |pt;
  assign sum_comb = |pt[NSUM_C-1:0];
  assign lvl_reg  = sum_reg  ^ ~cfg_pol;
  assign lvl_comb = sum_comb ^ ~cfg_pol;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= ~lvl_reg;
  end

  assign pin_out = cfg_comb ? lvl_comb : ~q;
  assign pin_oe  = cfg_comb ? pt[NTERM-1] : ~oe_n;
  assign fb      = cfg_comb ? (pin_oe ? pin_out : pin_in) : q;
endmodule

module pal_macrocell_chk #(
  parameter int NTERM = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NTERM-1:0] pt,
  input logic             cfg_comb,
  input logic             cfg_pol,
  input logic             oe_n,
  input logic             pin_in,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             fb
);
  p_reg_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_comb && !$past(rst)) |-> (pin_out == ($past(cfg_pol) ? $past(|pt) : !$past(|pt))));

  p_comb_low_pol_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_comb && pt[NTERM-2:0] == '0) |-> (pin_out == !cfg_pol));

  p_comb_top_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_comb && $past(cfg_comb) && $stable(pt[NTERM-2:0]) && $stable(cfg_pol)) |-> $stable(pin_out));

  p_comb_oe_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_comb |-> (pin_oe == pt[NTERM-1]));

  p_reg_oe_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_comb |-> (pin_oe != oe_n));

  p_reg_fb_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_comb |-> (fb != pin_out));

  p_comb_fb_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_comb |-> (fb == (pin_oe ? pin_out : pin_in)));

  p_reset_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !cfg_comb) |-> (pin_out && !fb));
endmodule

bind pal_macrocell pal_macrocell_chk #(.NTERM(NTERM)) u_chk (
  .clk(clk), .rst(rst), .pt(pt), .cfg_comb(cfg_comb), .cfg_pol(cfg_pol),
  .oe_n(oe_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
);

// File: tb/pal_macrocell_test.sv
`timescale 1ns/1ps
module pal_macrocell_test;
  localparam int NTERM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NTERM-1:0] pt = '0;
  logic cfg_comb = 1'b0, cfg_pol = 1'b1, oe_n = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_q = 0;
  bit m_after_rst = 0;

  always #10 clk = ~clk;

  pal_macrocell #(.NTERM(NTERM)) uut (
    .clk(clk), .rst(rst), .pt(pt), .cfg_comb(cfg_comb), .cfg_pol(cfg_pol),
    .oe_n(oe_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic bit any_set(input logic [NTERM-1:0] v, input int upto);
    bit r = 0;
    for (int i = 0; i < upto; i++) if (v[i]) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    bit target;
    target = cfg_pol ? any_set(pt, NTERM) : !any_set(pt, NTERM);
    m_after_rst = rst;
    if (rst) m_q = 0;
    else m_q = !target;
  end

  task automatic chk(input logic got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b pt=%b comb=%b pol=%b oe_n=%b pin_in=%b",
               req, what, got, exp, pt, cfg_comb, cfg_pol, oe_n, pin_in);
    end
  endtask

  task automatic compare();
    bit e_out, e_oe, e_fb, s7;
    if (!cfg_comb) begin
      e_out = !m_q;
      e_oe  = !oe_n;
      e_fb  = m_q;
      chk(pin_out, e_out, m_after_rst ? "R8" : "R1/R2", "pin_out");
      chk(pin_oe, e_oe, "R5", "pin_oe");
      chk(fb, e_fb, m_after_rst ? "R8" : "R6", "fb");
    end else begin
      s7    = any_set(pt, NTERM-1);
      e_out = cfg_pol ? s7 : !s7;
      e_oe  = pt[NTERM-1];
      e_fb  = e_oe ? e_out : pin_in;
      chk(pin_out, e_out, "R3/R2", "pin_out");
      chk(pin_oe, e_oe, "R4", "pin_oe");
      chk(fb, e_fb, "R7", "fb");
    end
  endtask

  task automatic step(input logic [NTERM-1:0] p, input logic c, input logic pl,
                      input logic o, input logic pi, input logic r);
    pt = p; cfg_comb = c; cfg_pol = pl; oe_n = o; pin_in = pi; rst = r;
    if (c) begin
      #1 compare();
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare();
    // R8 reset state
    step(8'h00, 0, 1, 0, 0, 1);
    // R1 top term alone counts in registered form
    step(8'h80, 0, 1, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h01, 0, 0, 1, 0, 0);
    step(8'h00, 0, 0, 1, 0, 0);
    // R5 shared enable toggling against top term
    step(8'h80, 0, 1, 1, 1, 0);
    step(8'h00, 0, 1, 0, 1, 0);
    // R3 top term excluded from comb sum; R4 enable from top term
    step(8'h80, 1, 1, 0, 0, 0);
    step(8'h80, 1, 0, 1, 1, 0);
    step(8'h40, 1, 1, 1, 0, 0);
    step(8'h3c, 1, 0, 0, 1, 0);
    // R7 dedicated input: enable low, pin_in toggles
    step(8'h00, 1, 1, 0, 1, 0);
    step(8'h00, 1, 1, 0, 0, 0);
    step(8'h7f, 1, 0, 1, 1, 0);
    // back to registered, then reset mid-run
    step(8'h10, 0, 1, 0, 0, 0);
    step(8'h10, 0, 1, 0, 0, 1);
    step(8'hff, 0, 0, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[7:0] & {8{rv[8]}}, rv[9], rv[10], rv[11], rv[12], (rv[15:13] == 3'd0));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule